// File: doc/BRIEF.md
# Table-Programmed 16-bit ALU

This block is a 16-bit arithmetic and logic unit. The instruction does not encode the operation. A 4-bit function number from the instruction selects one word of a small writable control table, and that word decides the operation. The table has sixteen 6-bit words. Each word holds a mode bit, a 4-bit function code and a stored carry-in bit. In boolean mode the function code is used as a truth table and is applied to each bit position of A and B. In arithmetic mode the function code picks one of five sums. Shift-type instructions override the function number and address word 14 or 15 instead. Besides computing, the block can return the addressed table word on the result path. It can also return that word and replace it with the low bits of B in the same operation.

Requests arrive on a valid/ready stream. A request transfers on a cycle where `in_valid` and `in_ready` are both high. The result appears in a single output register one cycle later, together with its carry and zero flags, and is offered on a second valid/ready stream. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output stays frozen and no new request is taken. A table write takes effect at the clock edge that accepts the request. Any request accepted after that edge sees the new word.

Top module: `prog_alu`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the arithmetic carry flag is 0. The table holds these words, listed by index: 0=0x0C, 1=0x0A, 2=0x08, 3=0x0E, 4=0x06, 5=0x10, 6=0x31, 7=0x32, 8=0x13, 9=0x14, 10=0x03, 11=0x04, 12=0x00, 13=0x0F, 14=0x0C, 15=0x0A. As operations these are: pass A, pass B, AND, OR, XOR, add, subtract, increment, decrement, add-with-flag, NOT A, A AND NOT B, zero, all ones, pass A, pass B.
- R2: A table word is laid out as bit 5 = stored carry-in, bit 4 = mode and bits 3:0 = function code f. With mode 0, result bit i equals f[2*A[i]+B[i]], and the carry output is 0.
- R3: With mode 1 and stored carry c, f=0 gives A+B+c, f=1 gives A+(NOT B)+c, f=2 gives A+c and f=3 gives A+0xFFFF+c. The carry output is bit 16 of the 17-bit sum.
- R4: With mode 1, f=4 gives A+B+flag. The flag is the carry output of the most recent accepted operation that used mode 1 with f from 0 to 4.
- R5: With mode 1 and f from 5 to 15, the result is A and the carry output is 0. The carry flag is left unchanged.
- R6: Operation code 1 (read) returns the addressed word zero-extended to 16 bits, with carry output 0, and leaves the table unchanged.
- R7: Operation code 2 (swap) returns the addressed word as in R6 and writes B[5:0] into that word for later requests. Operation codes 0 and 3 compute.
- R8: When `in_shift` is 1, the table address is 14 + `in_shift_sel` and `in_func` is ignored, for every operation code.
- R9: `out_zero` is 1 exactly when `out_result` is 0.
- R10: A request accepted in one cycle appears on the outputs after the next clock edge. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 2 | 0/3 compute, 1 read word, 2 read and write word |
| in_func | input | 4 | Table address from the instruction |
| in_shift | input | 1 | Force the address into the shift slots |
| in_shift_sel | input | 1 | Picks slot 14 (0) or 15 (1) |
| in_a | input | 16 | Operand A |
| in_b | input | 16 | Operand B; bits 5:0 are the new word on a swap |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 16 | Result or zero-extended table word |
| out_carry | output | 1 | Carry out |
| out_zero | output | 1 | Result is zero |

## Verification
The bench sweeps all sixteen truth tables over operand pairs that contain every bit combination. It also runs all arithmetic codes with both values of the stored carry. A wrong index order in the truth table would swap the A-only and B-only functions. A dropped carry-in would make subtract and increment come out one low. The add-with-flag code is chained after additions that overflow and additions that do not, and it is also run after unused arithmetic codes. A design that updated the flag on the wrong operations would then add a stale carry. Swaps are checked to return the old word while the next request sees the new one, and shift forcing is checked to ignore the function field. A stall with the output blocked shows whether the block drops or overwrites a held result.

// File: rtl/prog_alu_pkg.sv
package prog_alu_pkg;

  localparam int ENTRY_W   = 6;
  localparam int TT_W      = 4;
  localparam int TAB_DEPTH = 16;

  typedef struct packed {
    logic            cin;
    logic            arith;
    logic [TT_W-1:0] code;
  } alu_entry_t;

  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_READ  = 2'd1,
    OP_SWAP  = 2'd2,
    OP_EXEC2 = 2'd3
  } alu_op_e;

  localparam logic [TT_W-1:0] AR_ADD  = 4'd0;
  localparam logic [TT_W-1:0] AR_SUB  = 4'd1;
  localparam logic [TT_W-1:0] AR_INC  = 4'd2;
  localparam logic [TT_W-1:0] AR_DEC  = 4'd3;
  localparam logic [TT_W-1:0] AR_ADDF = 4'd4;

  function automatic alu_entry_t default_entry(input int idx);
    alu_entry_t e;
    case (idx)
      0:       e = '{cin: 1'b0, arith: 1'b0, code: 4'b1100};
      1:       e = '{cin: 1'b0, arith: 1'b0, code: 4'b1010};
      2:       e = '{cin: 1'b0, arith: 1'b0, code: 4'b1000};
      3:       e = '{cin: 1'b0, arith: 1'b0, code: 4'b1110};
      4:       e = '{cin: 1'b0, arith: 1'b0, code: 4'b0110};
      5:       e = '{cin: 1'b0, arith: 1'b1, code: AR_ADD};
      6:       e = '{cin: 1'b1, arith: 1'b1, code: AR_SUB};
      7:       e = '{cin: 1'b1, arith: 1'b1, code: AR_INC};
      8:       e = '{cin: 1'b0, arith: 1'b1, code: AR_DEC};
      9:       e = '{cin: 1'b0, arith: 1'b1, code: AR_ADDF};
      10:      e = '{cin: 1'b0, arith: 1'b0, code: 4'b0011};
      11:      e = '{cin: 1'b0, arith: 1'b0, code: 4'b0100};
      12:      e = '{cin: 1'b0, arith: 1'b0, code: 4'b0000};
      13:      e = '{cin: 1'b0, arith: 1'b0, code: 4'b1111};
      14:      e = '{cin: 1'b0, arith: 1'b0, code: 4'b1100};
      default: e = '{cin: 1'b0, arith: 1'b0, code: 4'b1010};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/prog_alu_table.sv
module prog_alu_table
  import prog_alu_pkg::*;
#(
  parameter int DEPTH = TAB_DEPTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output alu_entry_t    rd_entry,
  input  logic          wr_en,
  input  alu_entry_t    wr_entry
);

  alu_entry_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= default_entry(i);
    end else if (wr_en) begin
      mem[addr] <= wr_entry;
    end
  end

  assign rd_entry = mem[addr];

endmodule

// File: rtl/prog_alu_core.sv
module prog_alu_core
  import prog_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_entry_t        entry,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              flag_in,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              flag_upd
);

  logic [DATA_W-1:0] bool_res;
  logic [DATA_W-1:0] opnd;
  logic              cin_sel;
  logic              known;
  logic [DATA_W:0]   sum;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign bool_res[i] = entry.code[{a[i], b[i]}];
  end

  always_comb begin
    known   = 1'b1;
    cin_sel = entry.cin;
    case (entry.code)
      AR_ADD:  opnd = b;
      AR_SUB:  opnd = ~b;
      AR_INC:  opnd = '0;
      AR_DEC:  opnd = '1;
      AR_ADDF: begin
        opnd    = b;
        cin_sel = flag_in;
      end
      default: begin
        opnd  = '0;
        known = 1'b0;
      end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin_sel};

  always_comb begin
    if (!entry.arith) begin
      result = bool_res;
      carry  = 1'b0;
    end else if (known) begin
      result = sum[DATA_W-1:0];
      carry  = sum[DATA_W];
    end else begin
      result = a;
      carry  = 1'b0;
    end
  end

  assign flag_upd = entry.arith & known;

endmodule

// File: rtl/prog_alu_stage.sv
module prog_alu_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/prog_alu.sv
module prog_alu
  import prog_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int AW = $clog2(TAB_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [AW-1:0]     in_func,
  input  logic              in_shift,
  input  logic              in_shift_sel,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_zero
);

  localparam int PAY_W = DATA_W + 2;

  logic [AW-1:0]     tab_addr;
  alu_entry_t        entry;
  alu_entry_t        new_entry;
  logic              accept;
  logic              is_table_op;
  logic              do_write;
  logic              carry_flag;
  logic [DATA_W-1:0] core_res;
  logic              core_cy;
  logic              core_upd;
  logic [DATA_W-1:0] sel_res;
  logic              sel_cy;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  assign tab_addr    = in_shift ? {{(AW-1){1'b1}}, in_shift_sel} : in_func;
  assign accept      = in_valid && in_ready;
  assign is_table_op = (in_op == OP_READ) || (in_op == OP_SWAP);
  assign do_write    = accept && (in_op == OP_SWAP);
  assign new_entry   = in_b[ENTRY_W-1:0];

  prog_alu_table #(.DEPTH(TAB_DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (tab_addr),
    .rd_entry (entry),
    .wr_en    (do_write),
    .wr_entry (new_entry)
  );

  prog_alu_core #(.DATA_W(DATA_W)) u_core (
    .entry    (entry),
    .a        (in_a),
    .b        (in_b),
    .flag_in  (carry_flag),
    .result   (core_res),
    .carry    (core_cy),
    .flag_upd (core_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               carry_flag <= 1'b0;
    else if (accept && !is_table_op && core_upd) carry_flag <= core_cy;
  end

  always_comb begin
    if (is_table_op) begin
      sel_res = {{(DATA_W-ENTRY_W){1'b0}}, entry};
      sel_cy  = 1'b0;
    end else begin
      sel_res = core_res;
      sel_cy  = core_cy;
    end
  end

  assign pay_in = {(sel_res == '0), sel_cy, sel_res};

  prog_alu_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign out_result = pay_out[DATA_W-1:0];
  assign out_carry  = pay_out[DATA_W];
  assign out_zero   = pay_out[DATA_W+1];

endmodule

// File: rtl/prog_alu_chk.sv
module prog_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_carry,
  input logic              out_zero
);

  p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_accept_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_carry));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));

  p_word_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 2'd1 || in_op == 2'd2)
      |=> ((out_result >> 6) == '0) && !out_carry);

endmodule

bind prog_alu prog_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_carry  (out_carry),
  .out_zero   (out_zero)
);

// File: tb/test_prog_alu.sv
module test_prog_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [3:0]  in_func = 4'd0;
  logic        in_shift = 1'b0;
  logic        in_shift_sel = 1'b0;
  logic [15:0] in_a = 16'd0;
  logic [15:0] in_b = 16'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic        out_carry;
  logic        out_zero;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [5:0]  tab [16];
  logic        flag_m = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  prog_alu i_prog_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_func(in_func), .in_shift(in_shift),
    .in_shift_sel(in_shift_sel), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_carry(out_carry), .out_zero(out_zero)
  );

  function automatic logic [15:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[15:0];
  endfunction

  function automatic logic [16:0] model(input logic [5:0] e, input logic [15:0] a,
                                        input logic [15:0] b, input logic fl);
    logic [16:0] s;
    logic [16:0] c;
    c = {16'd0, e[5]};
    if (!e[4]) begin
      s = 17'd0;
      for (int i = 0; i < 16; i++) s[i] = e[a[i] * 2 + b[i]];
    end else begin
      case (e[3:0])
        4'd0:    s = {1'b0, a} + {1'b0, b} + c;
        4'd1:    s = {1'b0, a} + 17'd65535 - {1'b0, b} + c;
        4'd2:    s = {1'b0, a} + c;
        4'd3:    s = {1'b0, a} + 17'd65535 + c;
        4'd4:    s = {1'b0, a} + {1'b0, b} + {16'd0, fl};
        default: s = {1'b0, a};
      endcase
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic [1:0] op, input logic [3:0] fn,
                       input logic sh, input logic ss, input logic [15:0] a,
                       input logic [15:0] b);
    logic [3:0]  addr;
    logic [16:0] s;
    logic [5:0]  e;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_func = fn; in_shift = sh;
    in_shift_sel = ss; in_a = a; in_b = b;
    addr = sh ? {3'b111, ss} : fn;
    e = tab[addr];
    if (op == 2'd1 || op == 2'd2) begin
      s = {11'd0, e};
      if (op == 2'd2) tab[addr] = b[5:0];
    end else begin
      s = model(e, a, b, flag_m);
      if (e[4] && e[3:0] <= 4'd4) flag_m = s[16];
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, out_zero, out_carry, out_result},
          {1'b1, (s[15:0] == 16'd0), s[16], s[15:0]});
  endtask

  task automatic put(input logic [3:0] idx, input logic [5:0] w);
    do_op("R7", 2'd2, idx, 1'b0, 1'b0, rnd(), {10'd0, w});
  endtask

  initial begin
    tab[0] = 6'h0C; tab[1] = 6'h0A; tab[2] = 6'h08; tab[3] = 6'h0E;
    tab[4] = 6'h06; tab[5] = 6'h10; tab[6] = 6'h31; tab[7] = 6'h32;
    tab[8] = 6'h13; tab[9] = 6'h14; tab[10] = 6'h03; tab[11] = 6'h04;
    tab[12] = 6'h00; tab[13] = 6'h0F; tab[14] = 6'h0C; tab[15] = 6'h0A;
    repeat (3) @(negedge clk);
    check("R1", {16'd0, out_valid, in_ready, 1'b0}, {16'd0, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {16'd0, out_valid, in_ready, 1'b0}, {16'd0, 1'b0, 1'b1, 1'b0});

    for (int i = 0; i < 16; i++) do_op("R1", 2'd1, i[3:0], 1'b0, 1'b0, rnd(), rnd());
    for (int i = 0; i < 16; i++) do_op("R6", 2'd1, i[3:0], 1'b0, 1'b0, rnd(), rnd());
    for (int i = 0; i < 10; i++) do_op("R1", 2'd0, i[3:0], 1'b0, 1'b0, rnd(), rnd());

    for (int f = 0; f < 16; f++) begin
      put(4'd3, {2'b00, f[3:0]});
      do_op("R2", 2'd0, 4'd3, 1'b0, 1'b0, 16'hFF00, 16'hF0F0);
      do_op("R2", 2'd3, 4'd3, 1'b0, 1'b0, 16'h0000, 16'h0000);
      do_op("R2", 2'd0, 4'd3, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
      for (int k = 0; k < 6; k++) do_op("R2", 2'd0, 4'd3, 1'b0, 1'b0, rnd(), rnd());
    end

    for (int c = 0; c < 2; c++) begin
      for (int f = 0; f < 4; f++) begin
        put(4'd5, {c[0], 1'b1, f[3:0]});
        do_op("R3", 2'd0, 4'd5, 1'b0, 1'b0, 16'hFFFF, 16'h0001);
        do_op("R3", 2'd0, 4'd5, 1'b0, 1'b0, 16'h0000, 16'h0000);
        do_op("R3", 2'd0, 4'd5, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
        do_op("R3", 2'd0, 4'd5, 1'b0, 1'b0, 16'h8000, 16'h7FFF);
        for (int k = 0; k < 40; k++) do_op("R3", 2'd0, 4'd5, 1'b0, 1'b0, rnd(), rnd());
      end
    end

    put(4'd5, 6'h10);
    put(4'd6, 6'h14);
    do_op("R4", 2'd0, 4'd5, 1'b0, 1'b0, 16'hFFFF, 16'h0001);
    do_op("R4", 2'd0, 4'd6, 1'b0, 1'b0, 16'h0000, 16'h0000);
    do_op("R4", 2'd0, 4'd5, 1'b0, 1'b0, 16'h0001, 16'h0001);
    do_op("R9", 2'd0, 4'd6, 1'b0, 1'b0, 16'h0000, 16'h0000);
    for (int k = 0; k < 60; k++)
      do_op("R4", 2'd0, (k % 3 == 0) ? 4'd5 : 4'd6, 1'b0, 1'b0, rnd(), rnd());

    for (int f = 5; f < 16; f++) begin
      put(4'd7, {1'b1, 1'b1, f[3:0]});
      do_op("R5", 2'd0, 4'd5, 1'b0, 1'b0, 16'hFFFF, 16'h0001);
      do_op("R5", 2'd0, 4'd7, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
      do_op("R5", 2'd0, 4'd7, 1'b0, 1'b0, rnd(), rnd());
      do_op("R5", 2'd0, 4'd6, 1'b0, 1'b0, 16'h0000, 16'h0000);
    end

    put(4'd14, 6'h0C);
    put(4'd15, 6'h0A);
    put(4'd2, 6'h0F);
    do_op("R8", 2'd0, 4'd2, 1'b1, 1'b0, 16'h1234, 16'hABCD);
    do_op("R8", 2'd0, 4'd2, 1'b1, 1'b1, 16'h1234, 16'hABCD);
    do_op("R8", 2'd1, 4'd0, 1'b1, 1'b1, rnd(), rnd());
    do_op("R8", 2'd2, 4'd0, 1'b1, 1'b0, rnd(), 16'h0008);
    do_op("R8", 2'd0, 4'd7, 1'b1, 1'b0, 16'h00F0, 16'h0FF0);
    do_op("R8", 2'd1, 4'd14, 1'b0, 1'b0, rnd(), rnd());

    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'd1; in_func = 4'd5; in_shift = 1'b0;
    @(negedge clk);
    check("R10", {2'b00, out_valid, in_ready, out_result},
          {2'b00, 1'b1, 1'b0, 10'd0, tab[5]});
    in_op = 2'd1; in_func = 4'd4;
    @(negedge clk);
    check("R10", {2'b00, out_valid, in_ready, out_result},
          {2'b00, 1'b1, 1'b0, 10'd0, tab[5]});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", {2'b00, out_valid, in_ready, out_result},
          {2'b00, 1'b1, 1'b1, 10'd0, tab[4]});
    @(negedge clk);
    check("R10", {17'd0, out_valid, in_ready}, {17'd0, 1'b0, 1'b1});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule